// File: doc/BRIEF.md
# PN Replica Extrapolator and Verification Correlator

This block checks a candidate code phase for a spreading sequence. A start strobe hands it a 22-bit estimate of the sequence generator state. From that estimate it builds the full 1024-chip local replica, one chip per cycle, using the recurrence of the generator polynomial D^22 + D + 1. It reads the stored quantized channel samples from a memory port, one per chip, and sums them into a signed correlation. A sample is added when its replica chip is 0 and subtracted when the chip is 1.

The window is split into four quarters. At the end of each of the first three quarters, the running sum must be above a programmable checkpoint threshold. If it is not, the block gives up at once and flags an early abort. This saves the rest of the window for a candidate that is plainly wrong. After the last chip, acquisition is declared only if the total is above the final threshold. Thresholds and seed are captured when a run starts. The estimator that produces the seed and the sample capture path sit outside this block.

Top module: `pn_verify_corr`

## Requirements
- R1: After reset, busy_o, done_o, acq_o, abort_o and rd_en_o are all 0.
- R2: A start_i seen while idle captures seed_i, cp_thr_i and fin_thr_i, and busy_o is 1 from the next cycle. A start_i seen while busy_o is 1 is ignored. Changing the seed or the thresholds during a run has no effect on that run's result or timing.
- R3: Replica chip k, for k from 0 to 21, equals seed_i[k]. Every later chip k up to 1023 equals chip k-1 XOR chip k-22.
- R4: rd_data_i is a 4-bit two's complement metric. It is added to the sum when its chip is 0 and subtracted when its chip is 1. The sum starts at 0 on each run.
- R5: While rd_en_o is 1, rd_addr_o steps by one each cycle, starting from 0 on each run. Read data for an address is taken in the cycle after that address is presented.
- R6: After chip 256*s+255, for s = 0, 1, 2, the sum is compared, as a signed number, with checkpoint threshold s. That threshold sits at bits [14*s+13:14*s] of cp_thr_i. If the sum is not strictly greater, the run ends with abort_o = 1 and acq_o = 0.
- R7: After chip 1023, acq_o = 1 if the sum is strictly greater than fin_thr_i (signed). Otherwise acq_o = 0 and abort_o = 0.
- R8: done_o is a one-cycle pulse. busy_o is 0 in the cycle done_o is 1. acq_o and abort_o are never both 1. Both hold their values until the next accepted start.
- R9: Count the edge that samples start_i as edge 0. done_o is 1 after edge 1025 for a full window, and after edge 256*s+257 for an abort at checkpoint s.
- R10: The 14-bit sum covers every reachable total without wrapping, including -8192, the result of 1024 chips of 0 with metric -8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, honoured only when idle |
| seed_i | input | 22 | Generator state estimate, bit k is chip k |
| cp_thr_i | input | 42 | Three signed 14-bit checkpoint thresholds, threshold s at bits [14*s+13:14*s] |
| fin_thr_i | input | 14 | Signed final threshold |
| rd_en_o | output | 1 | Channel metric read enable |
| rd_addr_o | output | 10 | Channel metric read address |
| rd_data_i | input | 4 | Signed channel metric, valid the cycle after its address |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| acq_o | output | 1 | Acquisition declared |
| abort_o | output | 1 | Run stopped at a checkpoint |

## Verification
Two things can land on the same edge: the checkpoint decision that ends a run, and the fetch side moving on to the next address. A third can land there too: a start strobe arriving while a run is active. For each case the bench computes the partial sums from its own replica. It then sets each threshold to exactly the partial sum, which fails, or one below it, which passes. This places the stop on a chosen boundary chip. It then judges the done cycle count, the flags and the address sequence against those values. A start strobe with a different seed and thresholds is pulsed in the middle of one run. The outcome and the timing of that run must still match the first capture.

// File: rtl/pn_corr_pkg.sv
package pn_corr_pkg;
  // sign-extend a metric to the accumulator width and apply the chip polarity
  function automatic logic signed [31:0] chip_term(input logic signed [31:0] m, input logic neg);
    return neg ? -m : m;
  endfunction
endpackage

// File: rtl/pn_replica_gen.sv
module pn_replica_gen #(
  parameter int SEED_W = 22,
  parameter int LAG    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SEED_W-1:0] seed_i,
  input  logic              adv_i,
  output logic              bit_o
);
  // sr_q[j] holds chip k+j while chip k is presented
  logic [SEED_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (load_i) sr_q <= seed_i;
    else if (adv_i)  sr_q <= {sr_q[SEED_W-LAG] ^ sr_q[0], sr_q[SEED_W-1:1]};
  end

  assign bit_o = sr_q[0];

  p_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i |=> sr_q[SEED_W-2:0] == $past(sr_q[SEED_W-1:1]));
endmodule

// File: rtl/pn_corr_accum.sv
module pn_corr_accum
  import pn_corr_pkg::*;
#(
  parameter int MET_W = 4,
  parameter int IDX_W = 10,
  parameter int SEGS  = 4,
  parameter int ACC_W = 14
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic [(SEGS-1)*ACC_W-1:0]   cp_thr_i,
  input  logic [ACC_W-1:0]            fin_thr_i,
  input  logic                        vld_i,
  input  logic                        neg_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic signed [MET_W-1:0]     metric_i,
  output logic                        stop_o,
  output logic                        done_o,
  output logic                        acq_o,
  output logic                        abort_o
);
  localparam int SEG_W  = $clog2(SEGS);
  localparam int SEG_SH = IDX_W - SEG_W;

  logic signed [ACC_W-1:0] thr_in [SEGS];
  logic signed [ACC_W-1:0] thr_q  [SEGS];
  logic signed [ACC_W-1:0] acc_q, acc_nx, term;
  logic [SEG_W-1:0] seg;
  logic seg_end, is_last, pass;

  for (genvar s = 0; s < SEGS; s++) begin : g_thr
    if (s < SEGS-1) begin : g_cp
      assign thr_in[s] = cp_thr_i[s*ACC_W +: ACC_W];
    end else begin : g_fin
      assign thr_in[s] = fin_thr_i;
    end
  end

  always_comb begin
    term    = ACC_W'(chip_term(32'(metric_i), neg_i));
    acc_nx  = acc_q + term;
    seg     = idx_i[IDX_W-1 -: SEG_W];
    seg_end = &idx_i[SEG_SH-1:0];
    is_last = (seg == SEG_W'(SEGS-1));
    pass    = acc_nx > thr_q[seg];
    stop_o  = vld_i && seg_end && (is_last || !pass);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0; done_o <= 1'b0; acq_o <= 1'b0; abort_o <= 1'b0;
      for (int s = 0; s < SEGS; s++) thr_q[s] <= '0;
    end else if (clr_i) begin
      acc_q <= '0; done_o <= 1'b0; acq_o <= 1'b0; abort_o <= 1'b0;
      for (int s = 0; s < SEGS; s++) thr_q[s] <= thr_in[s];
    end else begin
      done_o <= stop_o;
      if (vld_i) acc_q <= acc_nx;
      if (stop_o) begin
        acq_o   <= is_last && pass;
        abort_o <= !is_last && !pass;
      end
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && !clr_i && term >= 0 |-> acc_nx >= acc_q);
  p_no_underflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && !clr_i && term < 0 |-> acc_nx < acc_q);
  p_flags_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(acq_o && abort_o));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/pn_verify_corr.sv
module pn_verify_corr #(
  parameter int SEED_W = 22,
  parameter int LAG    = 1,
  parameter int WIN    = 1024,
  parameter int SEGS   = 4,
  parameter int MET_W  = 4,
  localparam int IDX_W = $clog2(WIN),
  localparam int ACC_W = MET_W + IDX_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [SEED_W-1:0]         seed_i,
  input  logic [(SEGS-1)*ACC_W-1:0] cp_thr_i,
  input  logic [ACC_W-1:0]          fin_thr_i,
  output logic                      rd_en_o,
  output logic [IDX_W-1:0]          rd_addr_o,
  input  logic signed [MET_W-1:0]   rd_data_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      acq_o,
  output logic                      abort_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WIN-1);

  logic busy_q, fetch_q, vld_q, bit_q, launch, stop, chip_bit;
  logic [IDX_W-1:0] fidx_q, aidx_q;

  assign launch = start_i && !busy_q;

  pn_replica_gen #(.SEED_W(SEED_W), .LAG(LAG)) u_gen (
    .clk_i, .rst_ni, .load_i(launch), .seed_i, .adv_i(fetch_q), .bit_o(chip_bit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; fetch_q <= 1'b0; vld_q <= 1'b0; bit_q <= 1'b0;
      fidx_q <= '0; aidx_q <= '0;
    end else if (launch) begin
      busy_q <= 1'b1; fetch_q <= 1'b1; vld_q <= 1'b0; fidx_q <= '0;
    end else begin
      vld_q  <= fetch_q && !stop;
      bit_q  <= chip_bit;
      aidx_q <= fidx_q;
      if (stop) begin
        busy_q <= 1'b0; fetch_q <= 1'b0;
      end else if (fetch_q) begin
        fidx_q <= fidx_q + 1'b1;
        if (fidx_q == LAST) fetch_q <= 1'b0;
      end
    end
  end

  pn_corr_accum #(.MET_W(MET_W), .IDX_W(IDX_W), .SEGS(SEGS), .ACC_W(ACC_W)) u_acc (
    .clk_i, .rst_ni, .clr_i(launch), .cp_thr_i, .fin_thr_i,
    .vld_i(vld_q), .neg_i(bit_q), .idx_i(aidx_q), .metric_i(rd_data_i),
    .stop_o(stop), .done_o, .acq_o, .abort_o);

  assign rd_en_o   = fetch_q;
  assign rd_addr_o = fidx_q;
  assign busy_o    = busy_q;

  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o && $past(rd_en_o) |-> rd_addr_o == $past(rd_addr_o) + 1'b1);
  p_read_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> busy_o);
  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && !done_o);
endmodule

// File: tb/test_pn_verify_corr.sv
module test_pn_verify_corr;
  localparam int WIN = 1024, SEGS = 4, ACC_W = 14, IDX_W = 10, SEG_LEN = 256;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, rd_en, busy, done, acq, abort;
  logic [21:0] seed;
  logic [(SEGS-1)*ACC_W-1:0] cp_thr;
  logic [ACC_W-1:0] fin_thr;
  logic [IDX_W-1:0] rd_addr;
  logic signed [3:0] rd_data;

  pn_verify_corr i_pn_verify_corr (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .seed_i(seed), .cp_thr_i(cp_thr),
    .fin_thr_i(fin_thr), .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .busy_o(busy), .done_o(done), .acq_o(acq), .abort_o(abort));

  logic signed [3:0] mem [WIN];
  bit rep [WIN];
  int psum [SEGS];
  int checks = 0, errors = 0, addr_track = 0, addr_err = 0;

  always @(posedge clk) if (rd_en) begin
    rd_data <= mem[rd_addr];
    if (int'(rd_addr) != addr_track) addr_err++;
    addr_track++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic gen_rep(input logic [21:0] sd);  // R3 recurrence
    for (int k = 0; k < WIN; k++) rep[k] = (k < 22) ? sd[k] : rep[k-1] ^ rep[k-22];
  endtask

  task automatic sums();  // R4 polarity
    int acc = 0;
    for (int k = 0; k < WIN; k++) begin
      acc += rep[k] ? -int'(mem[k]) : int'(mem[k]);
      if (k % SEG_LEN == SEG_LEN-1) psum[k/SEG_LEN] = acc;
    end
  endtask

  task automatic run(input logic [21:0] sd, input int c0, input int c1, input int c2,
                     input int fin, input int e_acq, input int e_abort, input int e_lat,
                     input string tag, input bit poke);
    int lat = 0; bit got = 0;
    @(negedge clk);
    seed = sd; fin_thr = ACC_W'(fin);
    cp_thr = {ACC_W'(c2), ACC_W'(c1), ACC_W'(c0)};
    addr_track = 0; addr_err = 0; start = 1'b1;
    while (!got && lat < 3000) begin
      @(negedge clk); lat++; start = 1'b0;
      if (poke && lat == 100) begin
        start = 1'b1; seed = ~sd; fin_thr = ACC_W'(-8192); cp_thr = '1;
      end
      if (done) got = 1;
    end
    chk({tag, " R9 done latency"}, got ? lat : -1, e_lat);
    chk({tag, " R7 acq"}, int'(acq), e_acq);
    chk({tag, " R6 abort"}, int'(abort), e_abort);
    chk({tag, " R8 busy at done"}, int'(busy), 0);
    chk({tag, " R5 read addresses"}, addr_err, 0);
    @(negedge clk);
    chk({tag, " R8 done pulse"}, int'(done), 0);
    chk({tag, " R8 flags held"}, int'(acq) + 2*int'(abort), e_acq + 2*e_abort);
  endtask

  task automatic run_mode(input logic [21:0] sd, input int mode, input string tag, input bit poke);
    int c[3];
    for (int s = 0; s < 3; s++) c[s] = (s < mode) ? psum[s] - 1 : (s == mode ? psum[s] : 0);
    if (mode < 3)
      run(sd, c[0], c[1], c[2], 0, 0, 1, SEG_LEN*mode + SEG_LEN + 2, tag, poke);
    else
      run(sd, c[0], c[1], c[2], psum[3] - (mode == 3 ? 1 : 0), mode == 3 ? 1 : 0, 0, WIN + 2, tag, poke);
  endtask

  initial begin
    int r;
    r = $urandom(32'd2024);
    rst_n = 1'b0; start = 1'b0; seed = '0; cp_thr = '0; fin_thr = '0;
    for (int k = 0; k < WIN; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0); chk("R1 done", int'(done), 0);
    chk("R1 acq", int'(acq), 0); chk("R1 abort", int'(abort), 0);
    chk("R1 rd_en", int'(rd_en), 0);
    rst_n = 1'b1;

    // R10: zero seed, all -8 reaches -8192; final equal -> no acquire
    for (int k = 0; k < WIN; k++) mem[k] = -4'sd8;
    gen_rep('0); sums();
    chk("R10 model min", psum[3], -8192);
    run('0, -8192, -8192, -8192, -8192, 0, 0, WIN + 2, "R10 min", 0);

    // R3/R4: positive extreme, final boundary both ways
    gen_rep(22'h2A5F3C);
    for (int k = 0; k < WIN; k++) mem[k] = rep[k] ? -4'sd8 : 4'sd7;
    sums();
    run_mode(22'h2A5F3C, 3, "R3 max acquire", 0);
    run_mode(22'h2A5F3C, 4, "R7 max equal", 0);

    // R6 aborts at first and last checkpoint
    gen_rep(22'h000001);
    for (int k = 0; k < WIN; k++) mem[k] = 4'($urandom_range(15, 0));
    sums();
    run_mode(22'h000001, 0, "R6 cp0", 0);
    run_mode(22'h000001, 2, "R6 cp2", 0);
    // R2: start during run ignored
    run_mode(22'h000001, 3, "R2 restart ignored", 1);

    for (int i = 0; i < 8; i++) begin
      logic [21:0] sd = 22'($urandom);
      gen_rep(sd);
      for (int k = 0; k < WIN; k++) mem[k] = 4'($urandom_range(15, 0));
      sums();
      run_mode(sd, $urandom_range(4, 0), "R4 random", 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog R9 actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule